// File: doc/BRIEF.md
# Two-Level Loop Step Controller

This block performs the loop step that may follow a virtual instruction in a table-driven code generator. Two table pointers are held in a small pointer set. Just below each pointer in byte memory is a one-byte loop count and some link words. On a start strobe the block reads the outer count below table pointer 0. When that count has run out, the block follows links to load a fresh pointer pair and a new virtual program counter. Otherwise it decrements the outer count and steps the inner count below table pointer 1. When the inner count runs out, table pointer 1 is reloaded from its own link.

The block has two forms. In the jump form, after the inner step the virtual program counter is redirected to a word stored below the current table pointer 1. In the plain test form, the program counter is left as it was when the outer count is nonzero. All memory traffic goes through one byte-wide port, one access per cycle, with read data returned the cycle after the request. Word values are little-endian: the low byte is at the lower address. A word is truncated to the address width. All address arithmetic wraps modulo 2^ADDR_W.

Top module: `loop_ctrl`

## Requirements
- R1: While reset is held and after its release, done_o, pc_load_o, busy_o, mem_re_o and mem_we_o are 0, and ptr0_o, ptr1_o and pc_o are 0.
- R2: After start_i is taken, the first access is a read of the outer count at ptr0-4. If that byte is nonzero, the next access is a write of the count minus one to the same address, followed by a read of the inner count at ptr1-4.
- R3: If the outer count is zero, nothing is written, and ptr0 is replaced by the word at old ptr0-2 (low byte at ptr0-2, high byte at ptr0-1).
- R4: In the zero-outer case, ptr1 is then loaded from the word at new ptr0-8, and pc_o from the word at new ptr0-6. pc_load_o is 1 in the done cycle.
- R5: If the inner count is zero, it is not written, and ptr1 is replaced by the word at ptr1-2.
- R6: If the inner count is nonzero, the inner count minus one is written back at ptr1-4 and ptr1 keeps its value.
- R7: With jump_i=1 and a nonzero outer count, after the inner step pc_o is loaded from the word at ptr1-6 (using ptr1 as it stands after the inner step), and pc_load_o is 1 in the done cycle.
- R8: With jump_i=0 and a nonzero outer count, pc_load_o stays 0 and pc_o keeps its prior value.
- R9: done_o is a one-cycle pulse. The number of cycles after the start edge is 2 for the outer read, plus 9 on the zero-outer path; otherwise plus 3, plus 3 if the inner count is zero or 1 if not, plus 3 for the jump form. A start_i while busy is ignored, and the pointer outputs hold while idle.
- R10: Address arithmetic wraps modulo 2^ADDR_W.
- R11: A memory read and a memory write are never requested in the same cycle. A word is read as two consecutive byte reads, low address first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a loop step (taken when idle) |
| jump_i | input | 1 | 1 = jump form, 0 = test form |
| ptr0_i | input | ADDR_W | current table pointer 0 |
| ptr1_i | input | ADDR_W | current table pointer 1 |
| ptr0_o | output | ADDR_W | resulting table pointer 0 |
| ptr1_o | output | ADDR_W | resulting table pointer 1 |
| pc_o | output | ADDR_W | virtual program counter value |
| pc_load_o | output | 1 | pc_o is to be loaded (with done_o) |
| done_o | output | 1 | loop step finished |
| busy_o | output | 1 | step in progress |
| mem_re_o | output | 1 | byte read request |
| mem_we_o | output | 1 | byte write request |
| mem_addr_o | output | ADDR_W | byte address |
| mem_wdata_o | output | 8 | write data |
| mem_rdata_i | input | 8 | read data, valid the cycle after mem_re_o |

## Verification
The bench builds the block with ADDR_W=12. This keeps a whole-address-space byte memory to 4096 entries, so every address the block can form is backed by real data. It also places pointers a few bytes above zero, which makes the downward offsets wrap past the bottom of the space. A chain of repeated steps counts an outer loop down through several inner reloads until it runs out. This reaches the count-zero, inner-zero and chained-reload paths in both instruction forms.

// File: rtl/loop_pkg.sv
package loop_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_OC_A, S_OC_D, S_OC_W, S_IC_A, S_IC_D, S_IC_W,
    S_WLO, S_WHI, S_WEND, S_DONE
  } st_e;

  typedef enum logic [2:0] {
    WT_P0_RELOAD, WT_P1_CHAIN, WT_PC_CHAIN, WT_P1_RELOAD, WT_PC_JUMP
  } wtask_e;

  localparam logic [3:0] OFS_CNT  = 4'd4;
  localparam logic [3:0] OFS_LINK = 4'd2;
  localparam logic [3:0] OFS_PC   = 4'd6;
  localparam logic [3:0] OFS_P1   = 4'd8;
  localparam int         BYTE_W   = 8;
  localparam int         WORD_W   = 2 * BYTE_W;
endpackage

// File: rtl/loop_addr_gen.sv
module loop_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] ptr0_i,
  input  logic [ADDR_W-1:0] ptr1_i,
  input  logic              sel_p1_i,
  input  logic [3:0]        ofs_i,
  input  logic              hi_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  always_comb begin
    base   = sel_p1_i ? ptr1_i : ptr0_i;
    // base - offset (+1 for the high byte), modulo 2^ADDR_W
    addr_o = base - ADDR_W'(ofs_i) + ADDR_W'(hi_i);
  end
endmodule

// File: rtl/loop_word_asm.sv
module loop_word_asm #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_lo_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] word_o
);
  localparam int WORD_W = loop_pkg::WORD_W;
  logic [7:0]        lo_q;
  logic [WORD_W-1:0] full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lo_q <= '0;
    else if (cap_lo_i) lo_q <= rdata_i;
  end

  always_comb begin
    full   = {rdata_i, lo_q};
    word_o = full[ADDR_W-1:0];
  end
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              jump_i,
  input  logic [ADDR_W-1:0] ptr0_i,
  input  logic [ADDR_W-1:0] ptr1_i,
  input  logic [7:0]        rdata_i,
  input  logic [ADDR_W-1:0] word_i,
  output logic [ADDR_W-1:0] p0_o,
  output logic [ADDR_W-1:0] p1_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_load_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              re_o,
  output logic              we_o,
  output logic [7:0]        wdata_o,
  output logic              sel_p1_o,
  output logic [3:0]        ofs_o,
  output logic              hi_o,
  output logic              cap_lo_o
);
  st_e               st_q;
  wtask_e            tk_q;
  logic [ADDR_W-1:0] p0_q, p1_q, pc_q;
  logic [7:0]        cnt_q;
  logic              jmp_q, pc_upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      tk_q     <= WT_P0_RELOAD;
      p0_q     <= '0;
      p1_q     <= '0;
      pc_q     <= '0;
      cnt_q    <= '0;
      jmp_q    <= 1'b0;
      pc_upd_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          p0_q     <= ptr0_i;
          p1_q     <= ptr1_i;
          jmp_q    <= jump_i;
          pc_upd_q <= 1'b0;
          st_q     <= S_OC_A;
        end
        S_OC_A: st_q <= S_OC_D;
        S_OC_D: if (rdata_i == 8'd0) begin
          tk_q <= WT_P0_RELOAD;
          st_q <= S_WLO;
        end else begin
          cnt_q <= rdata_i - 8'd1;
          st_q  <= S_OC_W;
        end
        S_OC_W: st_q <= S_IC_A;
        S_IC_A: st_q <= S_IC_D;
        S_IC_D: if (rdata_i == 8'd0) begin
          tk_q <= WT_P1_RELOAD;
          st_q <= S_WLO;
        end else begin
          cnt_q <= rdata_i - 8'd1;
          st_q  <= S_IC_W;
        end
        S_IC_W: if (jmp_q) begin
          tk_q <= WT_PC_JUMP;
          st_q <= S_WLO;
        end else begin
          st_q <= S_DONE;
        end
        S_WLO: st_q <= S_WHI;
        S_WHI: st_q <= S_WEND;
        S_WEND: begin
          unique case (tk_q)
            WT_P0_RELOAD: begin
              p0_q <= word_i;
              tk_q <= WT_P1_CHAIN;
              st_q <= S_WLO;
            end
            WT_P1_CHAIN: begin
              p1_q <= word_i;
              tk_q <= WT_PC_CHAIN;
              st_q <= S_WLO;
            end
            WT_P1_RELOAD: begin
              p1_q <= word_i;
              if (jmp_q) begin
                tk_q <= WT_PC_JUMP;
                st_q <= S_WLO;
              end else begin
                st_q <= S_DONE;
              end
            end
            default: begin
              pc_q     <= word_i;
              pc_upd_q <= 1'b1;
              st_q     <= S_DONE;
            end
          endcase
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic w_state;
  always_comb begin
    w_state   = (st_q == S_WLO) || (st_q == S_WHI) || (st_q == S_WEND);
    re_o      = (st_q == S_OC_A) || (st_q == S_IC_A) ||
                (st_q == S_WLO) || (st_q == S_WHI);
    we_o      = (st_q == S_OC_W) || (st_q == S_IC_W);
    wdata_o   = cnt_q;
    hi_o      = (st_q == S_WHI);
    cap_lo_o  = (st_q == S_WHI);
    done_o    = (st_q == S_DONE);
    busy_o    = (st_q != S_IDLE);
    pc_load_o = done_o && pc_upd_q;
    sel_p1_o  = 1'b0;
    ofs_o     = OFS_CNT;
    if (st_q == S_IC_A || st_q == S_IC_D || st_q == S_IC_W) sel_p1_o = 1'b1;
    if (w_state) begin
      unique case (tk_q)
        WT_P0_RELOAD: begin sel_p1_o = 1'b0; ofs_o = OFS_LINK; end
        WT_P1_CHAIN:  begin sel_p1_o = 1'b0; ofs_o = OFS_P1;   end
        WT_PC_CHAIN:  begin sel_p1_o = 1'b0; ofs_o = OFS_PC;   end
        WT_P1_RELOAD: begin sel_p1_o = 1'b1; ofs_o = OFS_LINK; end
        default:      begin sel_p1_o = 1'b1; ofs_o = OFS_PC;   end
      endcase
    end
    p0_o = p0_q;
    p1_o = p1_q;
    pc_o = pc_q;
  end
endmodule

// File: rtl/loop_ctrl.sv
module loop_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              jump_i,
  input  logic [ADDR_W-1:0] ptr0_i,
  input  logic [ADDR_W-1:0] ptr1_i,
  output logic [ADDR_W-1:0] ptr0_o,
  output logic [ADDR_W-1:0] ptr1_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_load_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int MAX_AW = loop_pkg::WORD_W;
  if (ADDR_W > MAX_AW || ADDR_W < 4) begin : g_bad_aw
    initial $error("loop_ctrl: ADDR_W out of range");
  end

  logic              sel_p1, hi, cap_lo;
  logic [3:0]        ofs;
  logic [ADDR_W-1:0] word;

  loop_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .jump_i    (jump_i),
    .ptr0_i    (ptr0_i),
    .ptr1_i    (ptr1_i),
    .rdata_i   (mem_rdata_i),
    .word_i    (word),
    .p0_o      (ptr0_o),
    .p1_o      (ptr1_o),
    .pc_o      (pc_o),
    .pc_load_o (pc_load_o),
    .done_o    (done_o),
    .busy_o    (busy_o),
    .re_o      (mem_re_o),
    .we_o      (mem_we_o),
    .wdata_o   (mem_wdata_o),
    .sel_p1_o  (sel_p1),
    .ofs_o     (ofs),
    .hi_o      (hi),
    .cap_lo_o  (cap_lo)
  );

  loop_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .ptr0_i   (ptr0_o),
    .ptr1_i   (ptr1_o),
    .sel_p1_i (sel_p1),
    .ofs_i    (ofs),
    .hi_i     (hi),
    .addr_o   (mem_addr_o)
  );

  loop_word_asm #(.ADDR_W(ADDR_W)) u_wasm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_lo_i (cap_lo),
    .rdata_i  (mem_rdata_i),
    .word_o   (word)
  );
endmodule

// File: rtl/loop_ctrl_chk.sv
module loop_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pc_load_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o,
  input logic [7:0]        mem_rdata_i,
  input logic [ADDR_W-1:0] ptr0_o,
  input logic [ADDR_W-1:0] ptr1_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_re_o && !mem_we_o);

  p_one_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  p_write_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == $past(mem_rdata_i) - 8'd1) && ($past(mem_rdata_i) != 8'd0));

  p_write_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == $past(mem_addr_o, 2));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o);

  p_ptr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(ptr0_o) && $stable(ptr1_o));

  p_load_in_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> done_o);
endmodule

bind loop_ctrl loop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pc_load_o   (pc_load_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .ptr0_o      (ptr0_o),
  .ptr1_o      (ptr1_o)
);

// File: tb/loop_ctrl_test.sv
module loop_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int MSZ  = 1 << AW;
  localparam int MASK = MSZ - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, jump_i = 1'b0;
  logic [AW-1:0] ptr0_i = '0, ptr1_i = '0;
  logic [AW-1:0] ptr0_o, ptr1_o, pc_o, mem_addr_o;
  logic          pc_load_o, done_o, busy_o, mem_re_o, mem_we_o;
  logic [7:0]    mem_wdata_o, mem_rdata_i;

  loop_ctrl #(.ADDR_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .jump_i(jump_i),
    .ptr0_i(ptr0_i), .ptr1_i(ptr1_i), .ptr0_o(ptr0_o), .ptr1_o(ptr1_o),
    .pc_o(pc_o), .pc_load_o(pc_load_o), .done_o(done_o), .busy_o(busy_o),
    .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [7:0] mem [MSZ];
  logic [7:0] ref_mem [MSZ];
  initial mem_rdata_i = '0;
  always @(posedge clk_i) begin
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  typedef struct { bit we; int addr; int data; } op_t;
  op_t exp_q[$];
  int checks = 0, errors = 0;
  int e_p0, e_p1, e_pc, e_lat;
  bit e_ld;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input int v);
    mem[a & MASK] = 8'(v);
    ref_mem[a & MASK] = 8'(v);
  endtask

  task automatic pokew(input int a, input int v);
    poke(a, v & 255);
    poke(a + 1, (v >> 8) & 255);
  endtask

  function automatic int rw(input int a);
    return ({ref_mem[(a + 1) & MASK], ref_mem[a & MASK]}) & MASK;
  endfunction

  task automatic push_rd(input int a);
    exp_q.push_back('{0, a & MASK, 0});
  endtask

  task automatic push_rdw(input int a);
    push_rd(a);
    push_rd(a + 1);
  endtask

  // behavioural model of one loop step
  task automatic model(input int a0, input int a1, input bit j);
    int oc, ic, p0, p1;
    p0 = a0; p1 = a1;
    push_rd(p0 - 4);
    oc = ref_mem[(p0 - 4) & MASK];
    if (oc == 0) begin
      push_rdw(p0 - 2); p0 = rw(p0 - 2);
      push_rdw(p0 - 8); p1 = rw(p0 - 8);
      push_rdw(p0 - 6); e_pc = rw(p0 - 6);
      e_ld = 1; e_lat = 11;
    end else begin
      ref_mem[(p0 - 4) & MASK] = 8'(oc - 1);
      exp_q.push_back('{1, (p0 - 4) & MASK, oc - 1});
      push_rd(p1 - 4);
      ic = ref_mem[(p1 - 4) & MASK];
      if (ic == 0) begin
        push_rdw(p1 - 2); p1 = rw(p1 - 2);
        e_lat = 8;
      end else begin
        ref_mem[(p1 - 4) & MASK] = 8'(ic - 1);
        exp_q.push_back('{1, (p1 - 4) & MASK, ic - 1});
        e_lat = 6;
      end
      e_ld = 0;
      if (j) begin
        push_rdw(p1 - 6); e_pc = rw(p1 - 6);
        e_ld = 1; e_lat += 3;
      end
    end
    e_p0 = p0; e_p1 = p1;
  endtask

  task automatic run(input int a0, input int a1, input bit j, input string tag,
                     input bit junk_start);
    int n;
    op_t o;
    model(a0, a1, j);
    @(negedge clk_i);
    start_i = 1; jump_i = j; ptr0_i = AW'(a0); ptr1_i = AW'(a1);
    @(negedge clk_i);
    start_i = 0;
    n = 0;
    forever begin
      if (mem_re_o || mem_we_o) begin
        if (exp_q.size() == 0) begin
          chk(0, {tag, " R11 extra access"}, int'(mem_addr_o), -1);
        end else begin
          o = exp_q.pop_front();
          chk(mem_we_o == o.we && !(mem_re_o && mem_we_o) && int'(mem_addr_o) == o.addr &&
              (!o.we || int'(mem_wdata_o) == o.data),
              {tag, " R11 R2 access"}, {mem_we_o, 7'd0, mem_addr_o, mem_wdata_o},
              {o.we, 7'd0, o.addr[AW-1:0], o.data[7:0]});
        end
      end
      if (done_o || n > 40) break;
      if (junk_start && n == 2) begin
        start_i = 1; ptr0_i = ~AW'(a0); ptr1_i = ~AW'(a1); jump_i = ~j;
      end else start_i = 0;
      @(negedge clk_i);
      n++;
    end
    start_i = 0;
    chk(n == e_lat && done_o, {tag, " R9 latency"}, n, e_lat);
    chk(exp_q.size() == 0, {tag, " R11 missing access"}, exp_q.size(), 0);
    exp_q.delete();
    chk(int'(ptr0_o) == e_p0, {tag, " ptr0"}, ptr0_o, e_p0);
    chk(int'(ptr1_o) == e_p1, {tag, " ptr1"}, ptr1_o, e_p1);
    chk(pc_load_o == e_ld, {tag, " pc_load"}, pc_load_o, e_ld);
    chk(int'(pc_o) == e_pc, {tag, " pc"}, pc_o, e_pc);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R9 done pulse", done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) begin mem[i] = 8'(i * 7 + 3); ref_mem[i] = 8'(i * 7 + 3); end
    e_pc = 0;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !busy_o && !mem_re_o && !mem_we_o && !pc_load_o, "R1 in reset", done_o, 0);
    chk(ptr0_o == 0 && ptr1_o == 0 && pc_o == 0, "R1 regs", ptr0_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !mem_re_o && !mem_we_o, "R1 after release", busy_o, 0);

    // R2 R6 R8: both counts nonzero, test form
    poke(12'h300 - 4, 5); poke(12'h500 - 4, 3);
    run(12'h300, 12'h500, 0, "R2 R6 R8", 0);
    // R7: jump form, inner nonzero
    pokew(12'h500 - 6, 12'h9A7);
    run(12'h300, 12'h500, 1, "R7", 0);
    // R5 with jump: pc from new ptr1
    poke(12'h500 - 4, 0); pokew(12'h500 - 2, 12'h6C4);
    poke(12'h6C4 - 4, 2); pokew(12'h6C4 - 6, 12'h1B3);
    run(12'h300, 12'h500, 1, "R5 R7", 0);
    // R5 test form
    run(12'h300, 12'h500, 0, "R5 R8", 0);
    // R3 R4: outer zero chains to new pair
    poke(12'h300 - 4, 0); pokew(12'h300 - 2, 12'hA58);
    pokew(12'hA58 - 8, 12'h7E1); pokew(12'hA58 - 6, 12'h2F0);
    run(12'h300, 12'h500, 0, "R3 R4", 0);
    // R10: wrap below zero
    poke(12'h002 - 4, 1); poke(12'h001 - 4, 4); pokew(12'h001 - 6, 12'h4D2);
    run(12'h002, 12'h001, 1, "R10", 0);
    poke(12'h003 - 4, 0); pokew(12'h003 - 2, 12'h005);
    run(12'h003, 12'h400, 1, "R10 R3", 0);
    // R9: start while busy ignored
    poke(12'h700 - 4, 2); poke(12'h800 - 4, 1);
    run(12'h700, 12'h800, 0, "R9 busy start", 1);
    // chained count-down: outer 3, inner reload, until outer runs out
    poke(12'h900 - 4, 3); poke(12'hB00 - 4, 1); pokew(12'hB00 - 2, 12'hB00);
    pokew(12'hB00 - 6, 12'h123); pokew(12'h900 - 2, 12'hC40);
    pokew(12'hC40 - 8, 12'hD10); pokew(12'hC40 - 6, 12'h3AA);
    begin
      int q0, q1;
      q0 = 12'h900; q1 = 12'hB00;
      for (int k = 0; k < 6; k++) begin
        run(q0, q1, k[0], "R2 R5 R4 chain", 0);
        q0 = e_p0; q1 = e_p1;
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule